// File: doc/BRIEF.md
# Fault Signaling Pin Heartbeat Generator

This block drives one safety fault-signaling pin from a fast fixed base clock. While no fault is active, the pin carries a square-wave heartbeat with an exactly even duty cycle. The heartbeat period comes only from a programmable division factor. An external monitor treats the loss of this toggling as a sign that the device is unhealthy.

When a fault request arrives, the pin drops to its fault (low) level and stops toggling. It stays there for a programmable minimum hold time. That time is counted in whole heartbeat periods, and the count is built from two register fields joined together plus one. The heartbeat resumes only when the hold time has expired and software has also issued a clear. A clear given before expiry is remembered until expiry. A fresh fault request during the fault state starts the hold time again.

In the cycle-level rules below, D is the effective division factor and h = D/2 is the half-period in base-clock cycles. N is the fault-time value, with `time_hi` as the upper bits and `time_lo` as the lower bits.

Top module: `fault_pin_heartbeat`

## Requirements
- R1: The first cycle after reset release shows `pin` high and `in_fault` low. A fresh half-period starts at reset release, so `pin` stays high for h cycles, counting that first cycle.
- R2: In the fault-free state, `pin` is high for h cycles and then low for h cycles, repeating.
- R3: An odd `div_set` value is rounded down to the next even value, so h = (div_set-1)/2.
- R4: A `div_set` value below 2 acts as 2. A value above MAX_DIV (default 4096) acts as MAX_DIV.
- R5: If `fault_set` is sampled high on a clock edge, the cycle that follows shows `pin` low and `in_fault` high. While `in_fault` is high, `pin` does not toggle.
- R6: The fault lasts for a minimum of (N+1)·D base-clock cycles, measured from the entry edge. Take the case where a clear is already pending (`fault_clear` held high, or pulsed after entry) and D is held constant. Then `pin` stays low for exactly (N+1)·D+1 consecutive cycles, starting with the cycle after entry. Without a clear, the fault state never ends.
- R7: If `fault_clear` is sampled high after the hold time has expired, the cycle that follows shows `pin` high and `in_fault` low.
- R8: A `fault_set` sampled while in the fault state does two things. It restarts the hold time from that edge. It also discards any clear that was pending.
- R9: A `fault_clear` pulse in the fault-free state has no effect on the current heartbeat run. It is also not remembered for a later fault.
- R10: When the block leaves the fault state, the heartbeat starts a fresh half-period with `pin` high for h cycles.
- R11: A change to `div_set` has no effect on the half-period in progress. It takes effect from the next half-period boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock (fixed internal oscillator) |
| rst_n | input | 1 | Synchronous active-low reset |
| fault_set | input | 1 | Fault request, sampled each cycle |
| fault_clear | input | 1 | Software clear of the fault state |
| div_set | input | DIV_W (13) | Heartbeat division factor in base-clock cycles |
| time_hi | input | HI_W (8) | Upper field of the hold-time count |
| time_lo | input | LO_W (8) | Lower field of the hold-time count |
| pin | output | 1 | Fault signaling pin, high level means healthy |
| in_fault | output | 1 | High while the block is in the fault state |

## Verification
The assertions check several rules on every cycle:
- The pin is held low throughout the fault state.
- A fault request forces the fault level on the next cycle.
- The fault-free state never leaves without a request.
- The fault state never ends unless a clear is pending or being given.
- The first cycle after reset is high and not in fault.

Other behaviour depends on counts of cycles over windows that scale with the division factor and the hold-time fields. This covers the exact half-period lengths, odd-value rounding and clamping, the exact hold duration, restart on a repeated request, and when a new division factor takes effect. Only the bench's directed and random scenarios show these, by measuring run lengths at the pin.

// File: rtl/fpin_pkg.sv
// Package: shared types for the fault signaling pin generator.
// Assumes: nothing beyond a single clock domain.
package fpin_pkg;

    // Protocol state of the pin generator.
    typedef enum logic {
        ST_FREE  = 1'b0,
        ST_FAULT = 1'b1
    } pin_state_t;

endpackage

// File: rtl/fpin_prescaler.sv
// Module: fpin_prescaler
// Counts half-periods of the heartbeat from the base clock. It flags each
// half boundary and each full-period end, which is the tick for the hold timer.
// Assumes: MAX_DIV is even and at least 2. A new division factor is loaded only
// at a boundary or a restart, so a running half is never shortened.
module fpin_prescaler #(
    parameter int MAX_DIV = 4096,
    parameter int DIV_W   = $clog2(MAX_DIV + 1),
    parameter int HALF_W  = $clog2(MAX_DIV / 2 + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [DIV_W-1:0]  div_in,
    output logic              half_end,
    output logic              period_end,
    output logic              phase
);

    logic [HALF_W-1:0] hcnt_q;
    logic [HALF_W-1:0] cur_half_q;

    // Clamp the requested factor to [2, MAX_DIV], drop the odd bit, and halve it.
    function automatic logic [HALF_W-1:0] half_of(input logic [DIV_W-1:0] d);
        logic [DIV_W-1:0] c;
        if (d < DIV_W'(2))
            c = DIV_W'(2);
        else if (d > DIV_W'(MAX_DIV))
            c = DIV_W'(MAX_DIV);
        else
            c = d;
        return HALF_W'(c >> 1);
    endfunction

    // Decode the end of the current half and the end of a full period.
    always_comb begin
        half_end   = (hcnt_q == cur_half_q - HALF_W'(1));
        period_end = half_end && phase;
    end

    // Advance the half counter; reload length and flip phase at boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt_q     <= '0;
            phase      <= 1'b0;
            cur_half_q <= half_of(div_in);
        end else if (restart) begin
            hcnt_q     <= '0;
            phase      <= 1'b0;
            cur_half_q <= half_of(div_in);
        end else if (half_end) begin
            hcnt_q     <= '0;
            phase      <= !phase;
            cur_half_q <= half_of(div_in);
        end else begin
            hcnt_q     <= hcnt_q + HALF_W'(1);
        end
    end

endmodule

// File: rtl/fpin_hold_timer.sv
// Module: fpin_hold_timer
// Counts full heartbeat periods after a restart. It raises 'expired' once
// limit+1 ticks have been seen, and holds it until the next restart.
// Assumes: 'tick' is a one-cycle pulse per full period, aligned to the restart.
module fpin_hold_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Count ticks; flag expiry on the tick that follows count == limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            expired <= 1'b0;
        end else if (restart) begin
            cnt_q   <= '0;
            expired <= 1'b0;
        end else if (tick && !expired) begin
            if (cnt_q == limit)
                expired <= 1'b1;
            else
                cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/fpin_ctrl.sv
// Module: fpin_ctrl
// Protocol state machine. It switches between fault-free and fault states,
// remembers an early clear, and drives the registered pin level.
// Assumes: 'half_end' and 'phase' come from registers in the prescaler, so the
// restart decision forms no combinational loop.
module fpin_ctrl
    import fpin_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fault_set,
    input  logic fault_clear,
    input  logic expired,
    input  logic half_end,
    input  logic phase,
    output logic restart,
    output logic pin,
    output logic in_fault
);

    pin_state_t state_q, state_d;
    logic       pend_q, pend_d;
    logic       leave;
    logic       phase_d;
    logic       pin_d;

    // Next-state, pending-clear and next pin level; a request beats a clear.
    always_comb begin
        leave   = (state_q == ST_FAULT) && expired && (pend_q || fault_clear) && !fault_set;
        restart = fault_set || leave;

        state_d = state_q;
        if (fault_set)
            state_d = ST_FAULT;
        else if (leave)
            state_d = ST_FREE;

        pend_d = pend_q;
        if (restart)
            pend_d = 1'b0;
        else if ((state_q == ST_FAULT) && fault_clear)
            pend_d = 1'b1;

        phase_d = restart ? 1'b0 : (half_end ? !phase : phase);
        pin_d   = (state_d == ST_FREE) && !phase_d;
    end

    // State, pending clear and registered pin; reset lands in fault-free, pin high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FREE;
            pend_q  <= 1'b0;
            pin     <= 1'b1;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            pin     <= pin_d;
        end
    end

    // Export the state as a single flag.
    always_comb in_fault = (state_q == ST_FAULT);

endmodule

// File: rtl/fault_pin_heartbeat.sv
// Module: fault_pin_heartbeat (top)
// Fault signaling pin generator. It gives an even-duty heartbeat while healthy,
// and a held low level for at least ({time_hi,time_lo}+1) heartbeat periods
// after a fault.
// Assumes: one fixed base clock; all inputs synchronous to it.
module fault_pin_heartbeat #(
    parameter int  MAX_DIV = 4096,
    parameter int  HI_W    = 8,
    parameter int  LO_W    = 8,
    localparam int DIV_W   = $clog2(MAX_DIV + 1),
    localparam int HALF_W  = $clog2(MAX_DIV / 2 + 1),
    localparam int CNT_W   = HI_W + LO_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fault_set,
    input  logic             fault_clear,
    input  logic [DIV_W-1:0] div_set,
    input  logic [HI_W-1:0]  time_hi,
    input  logic [LO_W-1:0]  time_lo,
    output logic             pin,
    output logic             in_fault
);

    logic restart;
    logic half_end;
    logic period_end;
    logic phase;
    logic expired;

    fpin_prescaler #(
        .MAX_DIV (MAX_DIV),
        .DIV_W   (DIV_W),
        .HALF_W  (HALF_W)
    ) presc_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .div_in     (div_set),
        .half_end   (half_end),
        .period_end (period_end),
        .phase      (phase)
    );

    fpin_hold_timer #(
        .CNT_W (CNT_W)
    ) hold_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .tick    (period_end),
        .limit   ({time_hi, time_lo}),
        .expired (expired)
    );

    fpin_ctrl ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .fault_set   (fault_set),
        .fault_clear (fault_clear),
        .expired     (expired),
        .half_end    (half_end),
        .phase       (phase),
        .restart     (restart),
        .pin         (pin),
        .in_fault    (in_fault)
    );

endmodule

// File: rtl/fpin_checker.sv
// Module: fpin_checker
// Port-level protocol checks for fault_pin_heartbeat, attached by bind.
// Assumes: synchronous active-low reset.
module fpin_checker (
    input logic clk,
    input logic rst_n,
    input logic fault_set,
    input logic fault_clear,
    input logic pin,
    input logic in_fault
);

    logic was_rst;
    logic pend_c;

    // Remember that the previous edge was in reset.
    always_ff @(posedge clk) was_rst <= !rst_n;

    // Track a clear seen during the current fault, dropped by a new request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_c <= 1'b0;
        else
            pend_c <= in_fault && !fault_set && (pend_c || fault_clear);
    end

    // First cycle after reset: healthy level, not in fault (R1).
    always_ff @(posedge clk) begin
        if (rst_n && (was_rst === 1'b1))
            assert_reset_level_R1: assert (pin && !in_fault);
    end

    assert_fault_pin_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_fault |-> !pin);

    assert_entry_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fault_set |=> (in_fault && !pin));

    assert_exit_needs_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fault && !fault_set && !fault_clear && !pend_c) |=> in_fault);

    assert_free_stays_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_fault && !fault_set) |=> !in_fault);

endmodule

bind fault_pin_heartbeat fpin_checker chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .fault_set   (fault_set),
    .fault_clear (fault_clear),
    .pin         (pin),
    .in_fault    (in_fault)
);

// File: tb/fault_pin_heartbeat_tb_top.sv
module fault_pin_heartbeat_tb_top;

    localparam int MAX_DIV = 4096;
    localparam int HI_W    = 8;
    localparam int LO_W    = 8;
    localparam int DIV_W   = $clog2(MAX_DIV + 1);

    logic             clk = 1'b0;
    logic             rst_n;
    logic             fault_set;
    logic             fault_clear;
    logic [DIV_W-1:0] div_set;
    logic [HI_W-1:0]  time_hi;
    logic [LO_W-1:0]  time_lo;
    logic             pin;
    logic             in_fault;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = !clk;

    fault_pin_heartbeat #(.MAX_DIV(MAX_DIV), .HI_W(HI_W), .LO_W(LO_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .fault_set(fault_set), .fault_clear(fault_clear),
        .div_set(div_set), .time_hi(time_hi), .time_lo(time_lo),
        .pin(pin), .in_fault(in_fault)
    );

    function automatic int exp_half(int d);
        int c = d;
        if (c < 2) c = 2;
        if (c > MAX_DIV) c = MAX_DIV;
        return c / 2;
    endfunction

    function automatic int exp_low(int d, int hi, int lo);
        return ((hi * (1 << LO_W) + lo) + 1) * 2 * exp_half(d) + 1;
    endfunction

    task automatic check(int got, int exp, string req, string what);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic run_len(input logic v, output int n);
        n = 0;
        while (pin == v && n < 20000) begin
            n++;
            step();
        end
    endtask

    task automatic wait_change();
        logic s = pin;
        int g = 0;
        while (pin == s && g < 20000) begin
            g++;
            step();
        end
    endtask

    task automatic do_fault();
        fault_set = 1'b1;
        step();
        fault_set = 1'b0;
    endtask

    task automatic hb_check(int d, string req);
        int a, b;
        div_set = DIV_W'(d);
        wait_change();
        run_len(pin, a);
        run_len(pin, b);
        check(a, exp_half(d), req, $sformatf("first half div=%0d", d));
        check(b, exp_half(d), req, $sformatf("second half div=%0d", d));
    endtask

    task automatic held_fault(int d, int hi, int lo, string req);
        int n;
        div_set = DIV_W'(d);
        time_hi = HI_W'(hi);
        time_lo = LO_W'(lo);
        wait_change();
        fault_clear = 1'b1;
        do_fault();
        run_len(1'b0, n);
        fault_clear = 1'b0;
        check(n, exp_low(d, hi, lo), req, $sformatf("low run d=%0d hi=%0d lo=%0d", d, hi, lo));
    endtask

    initial begin
        int n, m, bad;
        logic v;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; fault_set = 1'b0; fault_clear = 1'b0;
        div_set = DIV_W'(8); time_hi = '0; time_lo = LO_W'(2);
        repeat (5) step();
        rst_n = 1'b1;

        // R1: reset state and fresh half-period.
        check(int'(pin), 1, "R1", "pin after reset");
        check(int'(in_fault), 0, "R1", "in_fault after reset");
        run_len(1'b1, n);
        check(n, 4, "R1", "first high run after reset");
        run_len(1'b0, n);
        check(n, 4, "R2", "first low run");

        // R2/R3/R4: directed factors.
        hb_check(6, "R2");
        hb_check(7, "R3");
        hb_check(13, "R3");
        hb_check(1, "R4");
        hb_check(0, "R4");
        hb_check(5000, "R4");
        hb_check(2, "R2");
        for (int i = 0; i < 6; i++) hb_check(2 + int'($urandom_range(38)), "R2");

        // R11: change mid-half keeps the running half.
        div_set = DIV_W'(8);
        wait_change();
        wait_change();
        v = pin;
        step(); step();
        div_set = DIV_W'(20);
        run_len(v, n);
        check(n + 2, 4, "R11", "half in progress after change");
        run_len(!v, n);
        check(n, 10, "R11", "first half with new factor");

        // R9: clear in fault-free leaves run untouched and is not remembered.
        div_set = DIV_W'(6);
        wait_change();
        wait_change();
        v = pin;
        fault_clear = 1'b1;
        step();
        fault_clear = 1'b0;
        run_len(v, n);
        check(n + 1, 3, "R9", "run length around free clear");
        check(int'(in_fault), 0, "R9", "in_fault after free clear");
        time_hi = '0; time_lo = LO_W'(1);
        do_fault();
        check(int'(pin), 0, "R5", "pin right after entry");
        check(int'(in_fault), 1, "R5", "in_fault right after entry");
        bad = 0;
        for (int i = 0; i < 2 * 6 + 20; i++) begin
            if (pin !== 1'b0 || in_fault !== 1'b1) bad++;
            step();
        end
        check(bad, 0, "R9", "fault held without clear");

        // R7: late clear exits next cycle; R10: fresh half after exit.
        fault_clear = 1'b1;
        step();
        fault_clear = 1'b0;
        check(int'(pin), 1, "R7", "pin after late clear");
        check(int'(in_fault), 0, "R7", "in_fault after late clear");
        run_len(1'b1, n);
        check(n, 3, "R10", "first high after exit");

        // R6: held clear, exact duration, field concatenation.
        held_fault(4, 0, 3, "R6");
        held_fault(2, 1, 2, "R6");

        // R6: early clear pulse remembered.
        div_set = DIV_W'(4); time_hi = '0; time_lo = LO_W'(2);
        do_fault();
        fault_clear = 1'b1;
        step();
        fault_clear = 1'b0;
        run_len(1'b0, n);
        check(n + 1, exp_low(4, 0, 2), "R6", "low run with early clear");

        // R8: repeated request restarts the hold time.
        fault_clear = 1'b1;
        do_fault();
        repeat (5) step();
        do_fault();
        run_len(1'b0, n);
        fault_clear = 1'b0;
        check(n, exp_low(4, 0, 2), "R8", "low run after restart");

        // R8: restart discards a pending clear.
        do_fault();
        fault_clear = 1'b1;
        step();
        fault_clear = 1'b0;
        do_fault();
        bad = 0;
        for (int i = 0; i < 3 * 4 + 15; i++) begin
            if (in_fault !== 1'b1) bad++;
            step();
        end
        check(bad, 0, "R8", "pending clear dropped by restart");
        fault_clear = 1'b1;
        step();
        fault_clear = 1'b0;
        check(int'(in_fault), 0, "R7", "exit after clear");

        // Random held-clear faults.
        for (int i = 0; i < 4; i++) begin
            m = 2 + int'($urandom_range(10));
            held_fault(m, 0, int'($urandom_range(7)), "R6");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule